// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Controller

This block collects interrupt requests for a small 8-bit microcontroller core. Eight internal sources (two general timers, two auxiliary timers, serial receive, serial transmit, bus arbitration and conversion-complete) raise one-cycle set pulses. Four external pins (two interrupt pins and two counter pins) pass through a two-flop synchroniser, and each pin has its own polarity bit that selects whether the rising or the falling edge counts. Every source owns a sticky request flag. The flag stays set until software writes a 0 to that bit.

Software reaches five byte registers through a simple write-strobe and combinational read port. These are two request registers, two enable registers and one polarity register. The block drives one combined interrupt line and a vector index that names the highest-priority enabled pending source. During a low-power state, one polarity-register bit can redirect the second interrupt pin's request to a key-press wake-up term. That term is true while any of eight port pins is low.

Top module: `irqUnit`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `vecIdx` is 0.
- R2: A 1 on `intSrc[i]` at a rising clock edge sets bit i of the internal request register (address 0xFC). The bit order is: 0 timer X, 1 timer Y, 2 timer 1, 3 timer 2, 4 serial receive, 5 serial transmit, 6 bus arbitration, 7 conversion complete.
- R3: A write to a request register (0xFC, or 0xFD for bits 3:0) clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a flag.
- R4: If a hardware set and a software clear hit the same bit on the same edge, the bit ends up set.
- R5: Enable registers 0xFE (8 bits) and 0xFF (bits 3:0) read back what was written. Bits 7:4 of 0xFD and 0xFF always read 0.
- R6: External request bits in 0xFD are 0 INT0 pin, 1 INT1 pin, 2 CNTR0 pin, 3 CNTR1 pin. Polarity bits 3:0 of 0xD4 use the same order, where 0 selects the falling edge and 1 the rising edge. A matching edge sets its flag on the third rising clock edge after the pin changes. An edge of the other direction sets nothing.
- R7: Writing a polarity bit while the pins are steady creates no request.
- R8: When bit 4 of 0xD4 is 1 and `lowPower` is 1, request bit 1 of 0xFD is set by any `keyPort` pin being low, on the third clock edge after it goes low. In that state the INT1 pin is ignored. Otherwise `keyPort` has no effect.
- R9: `irq` is 1 exactly when some request bit and its enable bit are both 1. It follows the registers with no extra cycle.
- R10: `vecIdx` gives the lowest-numbered enabled pending source. Numbers 0 to 3 are the 0xFD bits 0 to 3, and numbers 4 to 11 are the 0xFC bits 0 to 7. `vecIdx` is 0 when nothing is pending.
- R11: Bits 7:5 of 0xD4 read 0, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for busAddr |
| intSrc | input | 8 | Internal source set pulses |
| extPin | input | 4 | INT0, INT1, CNTR0, CNTR1 pins (bits 0..3) |
| keyPort | input | 8 | Key port pins for wake-up |
| lowPower | input | 1 | Stop or wait state active |
| irq | output | 1 | Combined interrupt request |
| vecIdx | output | 4 | Index of highest-priority pending source |

## Verification
Internal set pulses and register writes show up in the read data one clock edge after they are applied. `irq` and `vecIdx` are combinational from the flags, so they change in that same cycle. Pin and key-port changes take three edges: two synchroniser stages plus the flag. The bench therefore samples after the second edge and expects nothing, then samples after the third edge and expects the flag. All inputs change at the falling clock edge, and reads are taken a fraction of a period later, well away from the rising edge. The random phase keeps the pins still and compares every register, `irq` and `vecIdx` after each cycle with a bench model built from the requirements.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int DATA_W   = 8;
  localparam int NUM_INT  = 8;
  localparam int NUM_EXT  = 4;
  localparam int NUM_SRC  = NUM_INT + NUM_EXT;
  localparam int VEC_W    = $clog2(NUM_SRC);
  localparam int WAKE_BIT = NUM_EXT;
  localparam int POL_W    = NUM_EXT + 1;
  localparam int INT1_IDX = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_REQ1,
    SEL_REQ2,
    SEL_EN1,
    SEL_EN2,
    SEL_POL
  } rdSel_e;

  typedef struct packed {
    logic   wrReq1;
    logic   wrReq2;
    logic   wrEn1;
    logic   wrEn2;
    logic   wrPol;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  ADDR_REQ1 = 8'hFC,
  parameter logic [7:0]  ADDR_REQ2 = 8'hFD,
  parameter logic [7:0]  ADDR_EN1  = 8'hFE,
  parameter logic [7:0]  ADDR_EN2  = 8'hFF,
  parameter logic [7:0]  ADDR_POL  = 8'hD4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        stb
);

  logic hitReq1, hitReq2, hitEn1, hitEn2, hitPol;

  always_comb begin
    hitReq1 = (busAddr == ADDR_W'(ADDR_REQ1));
    hitReq2 = (busAddr == ADDR_W'(ADDR_REQ2));
    hitEn1  = (busAddr == ADDR_W'(ADDR_EN1));
    hitEn2  = (busAddr == ADDR_W'(ADDR_EN2));
    hitPol  = (busAddr == ADDR_W'(ADDR_POL));
  end

  always_comb begin
    stb.wrReq1 = busWrEn && hitReq1;
    stb.wrReq2 = busWrEn && hitReq2;
    stb.wrEn1  = busWrEn && hitEn1;
    stb.wrEn2  = busWrEn && hitEn2;
    stb.wrPol  = busWrEn && hitPol;
    if (hitReq1)      stb.rdSel = SEL_REQ1;
    else if (hitReq2) stb.rdSel = SEL_REQ2;
    else if (hitEn1)  stb.rdSel = SEL_EN1;
    else if (hitEn2)  stb.rdSel = SEL_EN2;
    else if (hitPol)  stb.rdSel = SEL_POL;
    else              stb.rdSel = SEL_NONE;
  end

  // R5: a single bus write touches at most one register
  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrReq1, stb.wrReq2, stb.wrEn1, stb.wrEn2, stb.wrPol}));

  // R11: no write strobe toward an unmapped address
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == SEL_NONE) |-> !(stb.wrReq1 || stb.wrReq2 || stb.wrEn1 || stb.wrEn2 || stb.wrPol));

endmodule

// File: rtl/irqPinSync.sv
module irqPinSync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  output logic pinSync,
  output logic pinPrev
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= {STAGES{RESET_VAL}};
      pinPrev <= RESET_VAL;
    end else begin
      chain   <= {chain[STAGES-2:0], pinRaw};
      pinPrev <= chain[STAGES-1];
    end
  end

  assign pinSync = chain[STAGES-1];

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_INT-1:0] intSrc,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [PORT_W-1:0]  keyPort,
  input  logic               lowPower,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq,
  output logic [VEC_W-1:0]   vecIdx
);

  logic [NUM_INT-1:0] req1, en1;
  logic [NUM_EXT-1:0] req2, en2;
  logic [POL_W-1:0]   pol;

  logic [NUM_EXT-1:0] pinSync, pinPrev, riseHit, fallHit, edgeHit, extSet;
  logic               keyLowSync, keyLowPrev, wakeMode;
  logic [NUM_SRC-1:0] pendAll;

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : gPin
      irqPinSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk    (clk),
        .rstN   (rstN),
        .pinRaw (extPin[g]),
        .pinSync(pinSync[g]),
        .pinPrev(pinPrev[g])
      );
    end
  endgenerate

  irqPinSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_keySync (
    .clk    (clk),
    .rstN   (rstN),
    .pinRaw (~&keyPort),
    .pinSync(keyLowSync),
    .pinPrev(keyLowPrev)
  );

  // edge history is taken on the raw synchronised pin; polarity applied afterwards
  always_comb begin
    riseHit  = pinSync & ~pinPrev;
    fallHit  = ~pinSync & pinPrev;
    edgeHit  = (pol[NUM_EXT-1:0] & riseHit) | (~pol[NUM_EXT-1:0] & fallHit);
    wakeMode = pol[WAKE_BIT] && lowPower;
    extSet   = edgeHit;
    if (wakeMode) extSet[INT1_IDX] = keyLowSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      req1 <= '0;
      req2 <= '0;
      en1  <= '0;
      en2  <= '0;
      pol  <= '0;
    end else begin
      req1 <= (stb.wrReq1 ? (req1 & wrData[NUM_INT-1:0]) : req1) | intSrc;
      req2 <= (stb.wrReq2 ? (req2 & wrData[NUM_EXT-1:0]) : req2) | extSet;
      if (stb.wrEn1) en1 <= wrData[NUM_INT-1:0];
      if (stb.wrEn2) en2 <= wrData[NUM_EXT-1:0];
      if (stb.wrPol) pol <= wrData[POL_W-1:0];
    end
  end

  always_comb begin
    pendAll = {req1 & en1, req2 & en2};
    irq     = |pendAll;
    vecIdx  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendAll[i]) vecIdx = VEC_W'(i);
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_REQ1: rdData = DATA_W'(req1);
      SEL_REQ2: rdData = DATA_W'(req2);
      SEL_EN1:  rdData = DATA_W'(en1);
      SEL_EN2:  rdData = DATA_W'(en2);
      SEL_POL:  rdData = DATA_W'(pol);
      default:  rdData = '0;
    endcase
  end

  // R3: without a request write, no flag ever drops
  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrReq1 |=> ((req1 & $past(req1)) == $past(req1)));

  // R3: a request write sets nothing that hardware did not set
  assert_write_inert_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrReq1 |=> ((req1 & ~$past(req1) & ~$past(intSrc)) == '0));

  // R4: hardware set beats a software clear on the same edge
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrReq1 |=> ((req1 & $past(intSrc)) == $past(intSrc)));

  // R10: the vector points at a source that is pending and enabled
  assert_vector_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|((pendAll >> vecIdx) & NUM_SRC'(1))));

  // R9: with no interrupt the vector rests at zero
  assert_idle_vector_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> (vecIdx == '0));

  // R8: key wake term cannot set INT1 outside wake mode unless the pin produced an edge
  assert_wake_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeMode && !edgeHit[INT1_IDX] && !(stb.wrReq2 == 1'b0 && req2[INT1_IDX]) && !req2[INT1_IDX])
      |=> !req2[INT1_IDX]);

endmodule

// File: rtl/irqUnit.sv
module irqUnit
  import irqPkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PORT_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ADDR_REQ1   = 8'hFC,
  parameter logic [7:0] ADDR_REQ2   = 8'hFD,
  parameter logic [7:0] ADDR_EN1    = 8'hFE,
  parameter logic [7:0] ADDR_EN2    = 8'hFF,
  parameter logic [7:0] ADDR_POL    = 8'hD4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_INT-1:0] intSrc,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [PORT_W-1:0]  keyPort,
  input  logic               lowPower,
  output logic               irq,
  output logic [VEC_W-1:0]   vecIdx
);

  regStrobe_t stb;

  irqCtrl #(
    .ADDR_W   (ADDR_W),
    .ADDR_REQ1(ADDR_REQ1),
    .ADDR_REQ2(ADDR_REQ2),
    .ADDR_EN1 (ADDR_EN1),
    .ADDR_EN2 (ADDR_EN2),
    .ADDR_POL (ADDR_POL)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWrEn(busWrEn),
    .busAddr(busAddr),
    .stb    (stb)
  );

  irqDatapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .PORT_W     (PORT_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (busWrData),
    .intSrc  (intSrc),
    .extPin  (extPin),
    .keyPort (keyPort),
    .lowPower(lowPower),
    .rdData  (busRdData),
    .irq     (irq),
    .vecIdx  (vecIdx)
  );

endmodule

// File: tb/test_irqUnit.sv
`timescale 1ns/100ps
module test_irqUnit;

  localparam logic [7:0] A_REQ1 = 8'hFC;
  localparam logic [7:0] A_REQ2 = 8'hFD;
  localparam logic [7:0] A_EN1  = 8'hFE;
  localparam logic [7:0] A_EN2  = 8'hFF;
  localparam logic [7:0] A_POL  = 8'hD4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] intSrc = 8'h00;
  logic [3:0] extPin = 4'hF;
  logic [7:0] keyPort = 8'hFF;
  logic       lowPower = 1'b0;
  logic       irq;
  logic [3:0] vecIdx;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [7:0] mReq1 = 0, mEn1 = 0;
  logic [3:0] mReq2 = 0, mEn2 = 0;
  logic [4:0] mPol = 0;

  always #2 clk = ~clk;

  irqUnit i_irqUnit (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .intSrc(intSrc),
    .extPin(extPin), .keyPort(keyPort), .lowPower(lowPower),
    .irq(irq), .vecIdx(vecIdx)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  function automatic logic [3:0] expVec(input logic [7:0] r1, input logic [7:0] e1,
                                        input logic [3:0] r2, input logic [3:0] e2);
    logic [11:0] p;
    p = {r1 & e1, r2 & e2};
    for (int i = 0; i < 12; i++) if (p[i]) return 4'(i);
    return 4'd0;
  endfunction

  // model of register updates for the random phase (pins held still)
  task automatic cycle();
    @(posedge clk);
    if (busWrEn && busAddr == A_REQ1) mReq1 = mReq1 & busWrData;
    mReq1 = mReq1 | intSrc;
    if (busWrEn && busAddr == A_REQ2) mReq2 = mReq2 & busWrData[3:0];
    if (busWrEn && busAddr == A_EN1) mEn1 = busWrData;
    if (busWrEn && busAddr == A_EN2) mEn2 = busWrData[3:0];
    if (busWrEn && busAddr == A_POL) mPol = busWrData[4:0];
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    busAddr = a;
    #0.3;
    v = busRdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    cycle();
    busWrEn = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), int'(e));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R0 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [7:0] addrTab [5];
    addrTab[0] = A_REQ1; addrTab[1] = A_REQ2; addrTab[2] = A_EN1;
    addrTab[3] = A_EN2;  addrTab[4] = A_POL;
    void'($urandom(32'd4711));

    repeat (4) @(negedge clk);
    // R1 reset state
    expectReg("R1 req1", A_REQ1, 8'h00);
    expectReg("R1 req2", A_REQ2, 8'h00);
    expectReg("R1 en1", A_EN1, 8'h00);
    expectReg("R1 en2", A_EN2, 8'h00);
    expectReg("R1 pol", A_POL, 8'h00);
    check("R1 irq", int'(irq), 0);
    check("R1 vecIdx", int'(vecIdx), 0);
    rstN = 1'b1;
    cycles(2);

    // random phase: internal sources and register writes
    for (int it = 0; it < 600; it++) begin
      intSrc = 8'($urandom & $urandom & $urandom);
      if ($urandom % 3 == 0) begin
        busWrEn = 1'b1;
        busAddr = addrTab[$urandom % 5];
        busWrData = 8'($urandom);
      end
      cycle();
      busWrEn = 1'b0;
      intSrc = 8'h00;
      expectReg("R2 R3 R4 req1", A_REQ1, mReq1);
      expectReg("R3 R5 req2", A_REQ2, {4'h0, mReq2});
      expectReg("R5 en1", A_EN1, mEn1);
      expectReg("R5 en2", A_EN2, {4'h0, mEn2});
      expectReg("R11 pol", A_POL, {3'h0, mPol});
      check("R9 irq", int'(irq), int'(|({mReq1 & mEn1, mReq2 & mEn2})));
      check("R10 vecIdx", int'(vecIdx), int'(expVec(mReq1, mEn1, mReq2, mEn2)));
    end

    // clean state
    wr(A_EN1, 8'h00); wr(A_EN2, 8'h00); wr(A_POL, 8'h00);
    wr(A_REQ1, 8'h00); wr(A_REQ2, 8'h00);
    cycles(3);
    expectReg("R3 cleared", A_REQ2, 8'h00);

    // R11 unmapped read and R5 upper bits
    expectReg("R11 unmapped", 8'h10, 8'h00);
    wr(A_EN2, 8'hFF);
    expectReg("R5 en2 upper", A_EN2, 8'h0F);
    wr(A_EN2, 8'h00);

    // R6 INT0 falling edge with polarity 0
    extPin[0] = 1'b0;
    cycles(2);
    expectReg("R6 int0 not before third edge", A_REQ2, 8'h00);
    cycles(1);
    expectReg("R6 int0 fall", A_REQ2, 8'h01);
    wr(A_REQ2, 8'hFE);
    expectReg("R3 clear int0", A_REQ2, 8'h00);

    // R6 INT0 rising with polarity 1, then falling ignored
    wr(A_POL, 8'h01);
    extPin[0] = 1'b1;
    cycles(3);
    expectReg("R6 int0 rise", A_REQ2, 8'h01);
    wr(A_REQ2, 8'h00);
    extPin[0] = 1'b0;
    cycles(4);
    expectReg("R6 int0 wrong edge", A_REQ2, 8'h00);

    // R6 CNTR1 rising only
    wr(A_POL, 8'h08);
    extPin[3] = 1'b0;
    cycles(4);
    expectReg("R6 cntr1 fall ignored", A_REQ2, 8'h00);
    extPin[3] = 1'b1;
    cycles(3);
    expectReg("R6 cntr1 rise", A_REQ2, 8'h08);
    wr(A_REQ2, 8'h00);

    // R7 polarity flips with steady pins
    wr(A_POL, 8'h0F);
    cycles(3);
    wr(A_POL, 8'h00);
    cycles(3);
    wr(A_POL, 8'h0F);
    cycles(3);
    expectReg("R7 no false edge", A_REQ2, 8'h00);
    wr(A_POL, 8'h00);

    // R9 R10 vector and masking
    intSrc = 8'h24;
    cycle();
    intSrc = 8'h00;
    expectReg("R2 bits 2 and 5", A_REQ1, 8'h24);
    check("R9 masked irq", int'(irq), 0);
    wr(A_EN1, 8'h20);
    check("R9 irq on", int'(irq), 1);
    check("R10 vec serial tx", int'(vecIdx), 9);
    wr(A_EN1, 8'hFF);
    check("R10 vec timer 1", int'(vecIdx), 6);
    extPin[1] = 1'b0;
    cycles(3);
    wr(A_EN2, 8'h02);
    check("R10 vec int1 above internal", int'(vecIdx), 1);
    wr(A_EN1, 8'h00); wr(A_EN2, 8'h00);
    wr(A_REQ1, 8'h00); wr(A_REQ2, 8'h00);
    check("R9 irq off", int'(irq), 0);

    // R4 set beats clear
    intSrc = 8'h08;
    busWrEn = 1'b1; busAddr = A_REQ1; busWrData = 8'h00;
    cycle();
    busWrEn = 1'b0; intSrc = 8'h00;
    expectReg("R4 set wins", A_REQ1, 8'h08);
    wr(A_REQ1, 8'hFF);
    expectReg("R3 write one inert", A_REQ1, 8'h08);
    wr(A_REQ1, 8'h00);

    // R8 wake path
    extPin[1] = 1'b1;
    cycles(4);
    wr(A_REQ2, 8'h00);
    wr(A_POL, 8'h10);
    lowPower = 1'b1;
    keyPort = 8'hEF;
    cycles(2);
    expectReg("R8 key not before third edge", A_REQ2, 8'h00);
    cycles(1);
    expectReg("R8 key low wakes", A_REQ2, 8'h02);
    keyPort = 8'hFF;
    cycles(3);
    wr(A_REQ2, 8'h00);
    extPin[1] = 1'b0;
    cycles(4);
    expectReg("R8 int1 pin ignored", A_REQ2, 8'h00);
    lowPower = 1'b0;
    keyPort = 8'h00;
    cycles(4);
    expectReg("R8 key ignored awake", A_REQ2, 8'h00);
    keyPort = 8'hFF;
    cycles(3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule